// File: doc/BRIEF.md
# GPIO Port with Function Mux

This block is a 16-pin general-purpose I/O port driven through a small register bus. Each pin is either under software GPIO control or handed to one of four peripherals. In GPIO mode a data register and a direction register drive the pad. In peripheral mode a 2-bit field per pin picks which peripheral drives the pad's output value and output enable.

The data and direction registers can be written whole. They also have separate write-1-to-set and write-1-to-clear addresses, so one pin can change without a read-modify-write. Pad inputs pass through a two-stage synchronizer that only samples pins whose input-enable bit is set. Every register can be read back, so software can save the port state and restore it.

Top module: `gpio_fmux_port`

## Requirements
- R1: After reset every register is 0, so every pin is a GPIO input with sampling off. Both `pad_oe_o` and `pad_out_o` are 0, and a read of any address returns 0.
- R2: Register word addresses are: 0 function enable, 1 data, 2 data set, 3 data clear, 4 direction, 5 direction set, 6 direction clear, 7 input enable, 8 function select (32 bits). A write to 0, 1, 4, 7 or 8 replaces the register. A read of 0, 4, 5, 6, 7 or 8 returns the register, zero-extended. A read of 2 or 3 returns the raw data register.
- R3: A write to the data set address sets exactly the data bits written as 1. A write to the data clear address clears exactly those bits. All other data bits keep their value.
- R4: The direction set and clear addresses work the same way on the direction register. A direction bit of 1 makes the pin an output.
- R5: A pin whose function-enable bit is 0 drives `pad_oe_o` from its direction bit and `pad_out_o` from its data bit. Pads follow a register write from the clock edge that takes the write.
- R6: A pin p whose function-enable bit is 1 takes its 2-bit peripheral number k from function-select bits [2p+1:2p]. It drives `pad_out_o[p]` from `per_out_i[16k+p]` and `pad_oe_o[p]` from `per_oe_i[16k+p]`.
- R7: A read of address 1 returns, per pin, one of three values. An output pin (direction 1) returns its data bit. An input pin with input enable 1 returns the synchronized pad value. An input pin with input enable 0 returns 0.
- R8: A pad change is seen in a read of address 1 only when that read is taken at the third rising edge after the change or later. Reads taken at the first and second edges return the old value.
- R9: Writes to unmapped addresses change nothing, and reads of unmapped addresses return 0. Read data bits above a register's width return 0.
- R10: A read request with `we_i` low is taken at a rising edge. Its data appears on `rdata_o` after that edge and holds until the next read is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | 16 | Pad input values |
| pad_out_o | output | 16 | Pad output values |
| pad_oe_o | output | 16 | Pad output enables |
| per_out_i | input | 64 | Peripheral outputs, peripheral k at bits [16k+15:16k] |
| per_oe_i | input | 64 | Peripheral output enables, same layout |

## Verification
Some behaviours are checked by assertions on every cycle. Set and clear writes must not disturb unwritten bits, and unmapped writes must leave every register as it was. GPIO-mode pins must follow the direction and data registers. A data read of an input pin with sampling off must return 0. Other behaviours only the bench scenarios can show. These are the peripheral selection through each pin's 2-bit field, including the top pin's field in the highest bits. They also include the exact three-edge delay from a pad change to a data read, and the reset state seen at the ports.

// File: rtl/gpio_fmux_pkg.sv
package gpio_fmux_pkg;
  typedef enum logic [3:0] {
    A_FEN    = 4'd0,
    A_DATA   = 4'd1,
    A_DSET   = 4'd2,
    A_DCLR   = 4'd3,
    A_DIR    = 4'd4,
    A_DIRSET = 4'd5,
    A_DIRCLR = 4'd6,
    A_INEN   = 4'd7,
    A_MUX    = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_fmux_regs.sv
module gpio_fmux_regs
  import gpio_fmux_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int SELW = 2,
  parameter int RW   = 32,
  localparam int MW  = NPIN * SELW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [3:0]      addr_i,
  input  logic [RW-1:0]   wdata_i,
  output logic [NPIN-1:0] fen_o,
  output logic [NPIN-1:0] data_o,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] inen_o,
  output logic [MW-1:0]   mux_o
);
  logic [NPIN-1:0] fen_q, data_q, dir_q, inen_q;
  logic [MW-1:0]   mux_q;
  logic [NPIN-1:0] wlo;
  logic            wr;

  assign wlo = wdata_i[NPIN-1:0];
  assign wr  = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      mux_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        A_FEN:    fen_q  <= wlo;
        A_DATA:   data_q <= wlo;
        A_DSET:   data_q <= data_q | wlo;
        A_DCLR:   data_q <= data_q & ~wlo;
        A_DIR:    dir_q  <= wlo;
        A_DIRSET: dir_q  <= dir_q | wlo;
        A_DIRCLR: dir_q  <= dir_q & ~wlo;
        A_INEN:   inen_q <= wlo;
        A_MUX:    mux_q  <= wdata_i[MW-1:0];
        default:  ;
      endcase
    end
  end

  assign fen_o  = fen_q;
  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign inen_o = inen_q;
  assign mux_o  = mux_q;

  // R3
  data_set_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_DSET) |=> (((data_q ^ $past(data_q)) & ~$past(wlo)) == '0)
                                 && ((data_q & $past(wlo)) == $past(wlo)));
  // R3
  data_clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_DCLR) |=> (((data_q ^ $past(data_q)) & ~$past(wlo)) == '0)
                                 && ((data_q & $past(wlo)) == '0));
  // R4
  dir_set_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_DIRSET) |=> (((dir_q ^ $past(dir_q)) & ~$past(wlo)) == '0));
  // R4
  dir_clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_DIRCLR) |=> (((dir_q ^ $past(dir_q)) & ~$past(wlo)) == '0));
  // R9
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i > A_MUX) |=> ($stable(fen_q) && $stable(data_q) && $stable(dir_q)
                                && $stable(inen_q) && $stable(mux_q)));
endmodule

// File: rtl/gpio_fmux_sync.sv
module gpio_fmux_sync #(
  parameter int NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pad_in_i,
  input  logic [NPIN-1:0] inen_i,
  output logic [NPIN-1:0] sync_o
);
  logic [NPIN-1:0] s1_q, s2_q;

  // first stage only samples enabled pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_in_i & inen_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/gpio_fmux_pinmux.sv
module gpio_fmux_pinmux #(
  parameter int NPIN  = 16,
  parameter int NFUNC = 4,
  localparam int SELW = $clog2(NFUNC),
  localparam int MW   = NPIN * SELW,
  localparam int PW   = NPIN * NFUNC
) (
  input  logic [NPIN-1:0] fen_i,
  input  logic [NPIN-1:0] data_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [MW-1:0]   mux_i,
  input  logic [PW-1:0]   per_out_i,
  input  logic [PW-1:0]   per_oe_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [SELW-1:0]  sel;
    logic [NFUNC-1:0] out_cand, oe_cand;
    assign sel = mux_i[p*SELW +: SELW];
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign out_cand[f] = per_out_i[f*NPIN + p];
      assign oe_cand[f]  = per_oe_i[f*NPIN + p];
    end
    assign pad_out_o[p] = fen_i[p] ? out_cand[sel] : data_i[p];
    assign pad_oe_o[p]  = fen_i[p] ? oe_cand[sel]  : dir_i[p];
  end
endmodule

// File: rtl/gpio_fmux_port.sv
module gpio_fmux_port
  import gpio_fmux_pkg::*;
#(
  parameter int NPIN  = 16,
  parameter int NFUNC = 4,
  parameter int RW    = 32,
  localparam int SELW = $clog2(NFUNC),
  localparam int MW   = NPIN * SELW,
  localparam int PW   = NPIN * NFUNC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [3:0]      addr_i,
  input  logic [RW-1:0]   wdata_i,
  output logic [RW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pad_in_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o,
  input  logic [PW-1:0]   per_out_i,
  input  logic [PW-1:0]   per_oe_i
);
  logic [NPIN-1:0] fen, data, dir, inen, sync;
  logic [MW-1:0]   mux;
  logic [NPIN-1:0] data_rd;
  logic [RW-1:0]   rd_c, rdata_q;
  logic            rd;

  gpio_fmux_regs #(.NPIN(NPIN), .SELW(SELW), .RW(RW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .fen_o(fen), .data_o(data), .dir_o(dir), .inen_o(inen), .mux_o(mux)
  );

  gpio_fmux_sync #(.NPIN(NPIN)) u_sync (
    .clk_i, .rst_ni, .pad_in_i, .inen_i(inen), .sync_o(sync)
  );

  gpio_fmux_pinmux #(.NPIN(NPIN), .NFUNC(NFUNC)) u_pinmux (
    .fen_i(fen), .data_i(data), .dir_i(dir), .mux_i(mux),
    .per_out_i, .per_oe_i, .pad_out_o, .pad_oe_o
  );

  // outputs read the register, enabled inputs the synchronizer, others 0
  assign data_rd = (data & dir) | (sync & inen & ~dir);
  assign rd      = req_i && !we_i;

  always_comb begin
    rd_c = '0;
    case (addr_i)
      A_FEN:                      rd_c[NPIN-1:0] = fen;
      A_DATA:                     rd_c[NPIN-1:0] = data_rd;
      A_DSET, A_DCLR:             rd_c[NPIN-1:0] = data;
      A_DIR, A_DIRSET, A_DIRCLR:  rd_c[NPIN-1:0] = dir;
      A_INEN:                     rd_c[NPIN-1:0] = inen;
      A_MUX:                      rd_c[MW-1:0]   = mux;
      default:                    ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_c;
  end

  assign rdata_o = rdata_q;

  // R5
  gpio_oe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir) & ~fen) == '0);
  // R5
  gpio_out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ data) & ~fen) == '0);
  // R7
  unsampled_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_DATA) |=> ((rdata_o[NPIN-1:0] & ~$past(dir) & ~$past(inen)) == '0));
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/gpio_fmux_port_test.sv
module gpio_fmux_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] pad_in_i = '0;
  logic [15:0] pad_out_o, pad_oe_o;
  logic [63:0] per_out_i = '0;
  logic [63:0] per_oe_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_fen, m_data, m_dir, m_inen;
  logic [31:0] m_mux;

  gpio_fmux_port uut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_out_o, .pad_oe_o, .per_out_i, .per_oe_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd0: m_fen  = d[15:0];
      4'd1: m_data = d[15:0];
      4'd2: m_data = m_data | d[15:0];
      4'd3: m_data = m_data & ~d[15:0];
      4'd4: m_dir  = d[15:0];
      4'd5: m_dir  = m_dir | d[15:0];
      4'd6: m_dir  = m_dir & ~d[15:0];
      4'd7: m_inen = d[15:0];
      4'd8: m_mux  = d;
      default: ;
    endcase
  endtask

  function automatic logic [15:0] exp_pad(bit want_oe);
    logic [15:0] r;
    for (int p = 0; p < 16; p++) begin
      int k;
      k = int'(m_mux[2*p +: 2]);
      if (m_fen[p]) r[p] = want_oe ? per_oe_i[16*k+p] : per_out_i[16*k+p];
      else          r[p] = want_oe ? m_dir[p] : m_data[p];
    end
    return r;
  endfunction

  // assumes pad_in_i stable for at least three edges
  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return {16'h0, m_fen};
      4'd1: return {16'h0, (m_data & m_dir) | (pad_in_i & m_inen & ~m_dir)};
      4'd2, 4'd3: return {16'h0, m_data};
      4'd4, 4'd5, 4'd6: return {16'h0, m_dir};
      4'd7: return {16'h0, m_inen};
      4'd8: return m_mux;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] hold;
    void'($urandom(32'h1234));
    m_fen = '0; m_data = '0; m_dir = '0; m_inen = '0; m_mux = '0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1: reset state at pads and every address
    check("R1 pad_oe", {16'h0, pad_oe_o}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out_o}, 32'h0);
    pad_in_i = 16'hFFFF;
    idle(3);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 read", v, 32'h0);
    end

    // R2: full writes and readback; R9 upper bits read as 0
    wr(4'd7, 32'hFFFF_0F0F);
    rd(4'd7, v); check("R2 R9 inen readback", v, 32'h0000_0F0F);
    wr(4'd8, 32'hC000_0001);
    rd(4'd8, v); check("R2 mux readback", v, 32'hC000_0001);
    wr(4'd4, 32'h0000_00FF);
    rd(4'd5, v); check("R2 dir at set addr", v, 32'h0000_00FF);

    // R3: set/clear data bits
    wr(4'd1, 32'h0000_F00F);
    wr(4'd2, 32'h0000_0330);
    rd(4'd2, v); check("R3 data set", v, 32'h0000_F33F);
    wr(4'd3, 32'h0000_9001);
    rd(4'd3, v); check("R3 data clear", v, 32'h0000_633E);

    // R4: set/clear direction bits
    wr(4'd5, 32'h0000_8000);
    wr(4'd6, 32'h0000_0003);
    rd(4'd4, v); check("R4 dir set/clear", v, 32'h0000_80FC);

    // R5: GPIO mode pads
    wr(4'd0, 32'h0);
    check("R5 oe", {16'h0, pad_oe_o}, {16'h0, m_dir});
    check("R5 out", {16'h0, pad_out_o}, {16'h0, m_data});

    // R6: pin 15 takes field [31:30], pin 0 field [1:0]
    per_out_i = 64'h8000_0000_0000_0000;
    per_oe_i  = 64'h0000_0000_0001_0000;
    wr(4'd0, 32'h0000_8001);
    check("R6 pin15 out from periph3", {31'h0, pad_out_o[15]}, 32'h1);
    check("R6 pin0 oe from periph1", {31'h0, pad_oe_o[0]}, 32'h1);
    check("R6 pads all", {pad_oe_o, pad_out_o}, {exp_pad(1'b1), exp_pad(1'b0)});

    // R7: three pin classes
    wr(4'd0, 32'h0);
    wr(4'd4, 32'h0000_000F);
    wr(4'd1, 32'h0000_0005);
    wr(4'd7, 32'h0000_00F0);
    pad_in_i = 16'hFFFF;
    idle(3);
    rd(4'd1, v); check("R7 data classes", v, 32'h0000_00F5);

    // R8: pad change seen only at third edge
    wr(4'd4, 32'h0); wr(4'd7, 32'hFFFF);
    pad_in_i = 16'h0000;
    idle(3);
    pad_in_i = 16'hA5C3;
    rd(4'd1, v); check("R8 first edge old", v, 32'h0);
    rd(4'd1, v); check("R8 second edge old", v, 32'h0);
    rd(4'd1, v); check("R8 third edge new", v, 32'h0000_A5C3);

    // R9: unmapped write ignored, unmapped read 0
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd4, v); check("R9 dir untouched", v, {16'h0, m_dir});
    rd(4'd0, v); check("R9 fen untouched", v, {16'h0, m_fen});
    rd(4'd12, v); check("R9 unmapped read", v, 32'h0);

    // R10: rdata holds across writes and idle cycles
    rd(4'd8, hold);
    wr(4'd8, 32'h1234_5678);
    idle(2);
    check("R10 hold", rdata_o, hold);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      pad_in_i  = 16'($urandom);
      per_out_i = {$urandom, $urandom};
      per_oe_i  = {$urandom, $urandom};
      a = 4'($urandom_range(0, 10));
      wr(a, $urandom);
      idle(2);
      check("R5 R6 random pad_oe", {16'h0, pad_oe_o}, {16'h0, exp_pad(1'b1)});
      check("R5 R6 random pad_out", {16'h0, pad_out_o}, {16'h0, exp_pad(1'b0)});
      a = 4'($urandom_range(0, 15));
      rd(a, v);
      check("R2 R7 random read", v, exp_rd(a));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule